// File: doc/BRIEF.md
# MDIO Management Interface Master

This block is a hardware master for the Ethernet MII management channel. It accepts one command at a time, either a read or a write of a single 16-bit PHY register. From that command it produces the complete serial frame on the MDC clock and on the bidirectional MDIO line. MDC is derived from the system clock by dividing it. Each half period of MDC lasts `HALF_DIV` system clocks, and MDC rests low whenever no transaction is running. MDIO leaves the block as three signals: a data output, an output enable and a data input. The pad tristate sits outside the block. The input passes through a synchronizer whose depth is chosen by a parameter.

A command is accepted when it is strobed while the block is idle. `busy_o` is high for the whole frame. `done_o` pulses for one cycle when the frame ends. A read returns its 16 bits on `rd_data_o`. The read path also checks that the PHY pulls the turnaround bit low. If the PHY does not, the master runs a recovery sequence of 32 idle MDC cycles with the line released. It then reports `error_o` and leaves the previous read data in place. The error flag stays set until the next command is accepted.

Top module: `mdio_master`

## Requirements
- R1: Each frame opens with 32 MDC cycles in which MDIO is driven (output enable 1) to logic 1.
- R2: Next comes the start pair 0 then 1, then the opcode (read = 1,0; write = 0,1), then the 5-bit PHY address, then the 5-bit register address. Each address goes out most significant bit first, one bit per MDC cycle, with MDIO driven.
- R3: MDIO output and output enable change only on the edge where MDC falls. Both stay constant for every system clock in which MDC is high.
- R4: A write continues with a driven turnaround of 1 then 0. The 16 data bits follow, MSB first. One final MDC cycle has the output enable off. The frame is 65 MDC cycles in total.
- R5: A read releases MDIO (output enable 0) from the turnaround onward. The line is sampled while MDC is high in the first turnaround cycle, and that value must be 0. The next 16 MDC high phases supply the data, MSB first. Two further released cycles follow. `rd_data_o` takes the new value at completion, and the frame is 65 MDC cycles.
- R6: If the sampled turnaround is 1, the master issues 32 more MDC cycles with MDIO released, for a frame of 79 cycles. It then asserts `error_o` together with `done_o` and leaves `rd_data_o` unchanged.
- R7: The MDC high and low phases each last `HALF_DIV` system clocks, and MDC is low whenever `busy_o` is low.
- R8: `busy_o` rises in the cycle after the accepting strobe. `done_o` is a one-cycle pulse, in the same cycle that `busy_o` falls.
- R9: A start strobe while `busy_o` is high is ignored: the running frame keeps its contents and no further frame follows.
- R10: `error_o` clears in the cycle after the next command is accepted.
- R11: After reset, MDC is low, the output enable is off, `busy_o`, `done_o` and `error_o` are 0, and `rd_data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start_i | input | 1 | Command strobe, taken only when idle |
| cmd_read_i | input | 1 | 1 = read, 0 = write |
| cmd_phy_i | input | 5 | PHY address |
| cmd_reg_i | input | 5 | Register address |
| cmd_wdata_i | input | 16 | Write data |
| rd_data_o | output | 16 | Last successfully read data |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | Turnaround check failed on last read |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO data out |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO data in |

## Verification
The bench builds the block with `HALF_DIV = 3` and `SYNC_STAGES = 2`. Even the longest frame, the 79-cycle recovery frame, then takes under 500 system clocks. The two-stage synchronizer still eats into a three-clock half period, so the bench checks that the sample point at the end of the MDC high phase leaves enough margin for a PHY model that changes the line just after MDC falls. Because the divider is short, the bench can measure every phase length and check hold stability on every MDC cycle of every frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PRE,
      ST_HDR,
      ST_WTA,
      ST_WDAT,
      ST_WEND,
      ST_RTA,
      ST_RDAT,
      ST_RTAIL,
      ST_RECOV
   } mdio_state_e;

   localparam logic [1:0] FRAME_START = 2'b01;
   localparam logic [1:0] OPC_READ    = 2'b10;
   localparam logic [1:0] OPC_WRITE   = 2'b01;

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
   parameter int HALF_DIV = 25
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic mdc_o,
   output logic bit_end_o
);
   localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

   logic [CW-1:0] cnt_q;
   logic          phase_q;
   logic          wrap;

   initial begin
      assert (HALF_DIV >= 1) else $error("HALF_DIV must be at least 1");
   end

   assign wrap      = (cnt_q == LAST);
   assign bit_end_o = run_i && phase_q && wrap;
   assign mdc_o     = phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         phase_q <= 1'b0;
      end else if (!run_i) begin
         cnt_q   <= '0;
         phase_q <= 1'b0;
      end else if (wrap) begin
         cnt_q   <= '0;
         phase_q <= ~phase_q;
      end else begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end

   a_r7_phase_len: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !wrap) |=> (phase_q == $past(phase_q)));

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
   import mdio_pkg::*;
#(
   parameter int AW        = 5,
   parameter int DW        = 16,
   parameter int PRE_LEN   = 32,
   parameter int RECOV_LEN = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          read_i,
   input  logic [AW-1:0] phy_i,
   input  logic [AW-1:0] reg_i,
   input  logic [DW-1:0] wdata_i,
   input  logic          bit_end_i,
   input  logic          din_i,
   output logic          run_o,
   output logic          mdio_o,
   output logic          mdio_oe_o,
   output logic [DW-1:0] rd_data_o,
   output logic          done_o,
   output logic          error_o
);
   localparam int HDR_W   = 4 + 2 * AW;
   localparam int MAX_A   = (PRE_LEN > RECOV_LEN) ? PRE_LEN : RECOV_LEN;
   localparam int MAX_B   = (DW > HDR_W) ? DW : HDR_W;
   localparam int MAX_LEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int CNT_W   = $clog2(MAX_LEN + 1);

   mdio_state_e      state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [HDR_W-1:0] hdr_q;
   logic [DW-1:0]    wsh_q;
   logic [DW-1:0]    rsh_q;
   logic [DW-1:0]    rdata_q;
   logic             is_rd_q;
   logic             err_q;
   logic             done_q;
   int               seg_len;
   logic             seg_last;
   logic             accept;

   initial begin
      assert (AW >= 1 && DW >= 2) else $error("address or data width too small");
      assert (PRE_LEN >= 1 && RECOV_LEN >= 1) else $error("run lengths must be positive");
   end

   always_comb begin
      case (state_q)
         ST_PRE:   seg_len = PRE_LEN;
         ST_HDR:   seg_len = HDR_W;
         ST_WTA:   seg_len = 2;
         ST_WDAT:  seg_len = DW;
         ST_RDAT:  seg_len = DW;
         ST_RTAIL: seg_len = 2;
         ST_RECOV: seg_len = RECOV_LEN;
         default:  seg_len = 1;
      endcase
   end

   assign seg_last = (int'(cnt_q) == seg_len - 1);
   assign accept   = (state_q == ST_IDLE) && start_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         hdr_q   <= '0;
         wsh_q   <= '0;
         rsh_q   <= '0;
         rdata_q <= '0;
         is_rd_q <= 1'b0;
         err_q   <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            state_q <= ST_PRE;
            cnt_q   <= '0;
            is_rd_q <= read_i;
            hdr_q   <= {FRAME_START, (read_i ? OPC_READ : OPC_WRITE), phy_i, reg_i};
            wsh_q   <= wdata_i;
            err_q   <= 1'b0;
         end else if (state_q != ST_IDLE && bit_end_i) begin
            if (state_q == ST_HDR)  hdr_q <= hdr_q << 1;
            if (state_q == ST_WDAT) wsh_q <= wsh_q << 1;
            if (state_q == ST_RDAT) rsh_q <= {rsh_q[DW-2:0], din_i};
            if (seg_last) begin
               cnt_q <= '0;
               case (state_q)
                  ST_PRE:   state_q <= ST_HDR;
                  ST_HDR:   state_q <= is_rd_q ? ST_RTA : ST_WTA;
                  ST_WTA:   state_q <= ST_WDAT;
                  ST_WDAT:  state_q <= ST_WEND;
                  ST_RTA:   state_q <= din_i ? ST_RECOV : ST_RDAT;
                  ST_RDAT:  state_q <= ST_RTAIL;
                  ST_WEND: begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                  end
                  ST_RTAIL: begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                     rdata_q <= rsh_q;
                  end
                  ST_RECOV: begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                     err_q   <= 1'b1;
                  end
                  default:  state_q <= ST_IDLE;
               endcase
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   always_comb begin
      mdio_oe_o = 1'b0;
      mdio_o    = 1'b0;
      case (state_q)
         ST_PRE:  begin mdio_oe_o = 1'b1; mdio_o = 1'b1;           end
         ST_HDR:  begin mdio_oe_o = 1'b1; mdio_o = hdr_q[HDR_W-1]; end
         ST_WTA:  begin mdio_oe_o = 1'b1; mdio_o = (cnt_q == '0);  end
         ST_WDAT: begin mdio_oe_o = 1'b1; mdio_o = wsh_q[DW-1];    end
         default: ;
      endcase
   end

   assign run_o     = (state_q != ST_IDLE);
   assign rd_data_o = rdata_q;
   assign done_o    = done_q;
   assign error_o   = err_q;

   a_r1_preamble_high: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PRE) |-> (mdio_oe_o && mdio_o));

   a_r2_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HDR && cnt_q == '0) |-> (mdio_oe_o && !mdio_o));

   a_r5_read_released: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rd_q && (state_q == ST_RTA || state_q == ST_RDAT || state_q == ST_RTAIL))
      |-> !mdio_oe_o);

   a_r6_recover_released: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RECOV) |-> !mdio_oe_o);

   a_r6_rdata_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RECOV) |=> $stable(rdata_q));

endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
   parameter int HALF_DIV    = 25,
   parameter int SYNC_STAGES = 2,
   parameter int AW          = 5,
   parameter int DW          = 16,
   parameter int PRE_LEN     = 32,
   parameter int RECOV_LEN   = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_start_i,
   input  logic          cmd_read_i,
   input  logic [AW-1:0] cmd_phy_i,
   input  logic [AW-1:0] cmd_reg_i,
   input  logic [DW-1:0] cmd_wdata_i,
   output logic [DW-1:0] rd_data_o,
   output logic          busy_o,
   output logic          done_o,
   output logic          error_o,
   output logic          mdc_o,
   output logic          mdio_o,
   output logic          mdio_oe_o,
   input  logic          mdio_i
);
   logic run;
   logic bit_end;
   logic din;

   initial begin
      assert (SYNC_STAGES >= 0 && SYNC_STAGES < 2 * HALF_DIV)
         else $error("SYNC_STAGES must fit inside one MDC period");
   end

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign din = mdio_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '1;
            end else begin
               chain_q[0] <= mdio_i;
               for (int k = 1; k < SYNC_STAGES; k++) chain_q[k] <= chain_q[k-1];
            end
         end
         assign din = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   mdio_mdc_gen #(.HALF_DIV(HALF_DIV)) u_mdc (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (run),
      .mdc_o     (mdc_o),
      .bit_end_o (bit_end)
   );

   mdio_frame_seq #(
      .AW(AW), .DW(DW), .PRE_LEN(PRE_LEN), .RECOV_LEN(RECOV_LEN)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (cmd_start_i),
      .read_i    (cmd_read_i),
      .phy_i     (cmd_phy_i),
      .reg_i     (cmd_reg_i),
      .wdata_i   (cmd_wdata_i),
      .bit_end_i (bit_end),
      .din_i     (din),
      .run_o     (run),
      .mdio_o    (mdio_o),
      .mdio_oe_o (mdio_oe_o),
      .rd_data_o (rd_data_o),
      .done_o    (done_o),
      .error_o   (error_o)
   );

   assign busy_o = run;

   a_r7_idle_mdc_low: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !mdc_o);

   a_r3_hold_in_high: assert property (@(posedge clk) disable iff (!rst_n)
      mdc_o |-> ($stable(mdio_o) && $stable(mdio_oe_o)));

   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o)));

   a_r6_error_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(error_o) |-> done_o);

   a_r10_error_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && cmd_start_i) |=> (!error_o && busy_o));

endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
   localparam int HALF = 3;

   typedef struct {
      logic        rd;
      logic [4:0]  phy;
      logic [4:0]  rg;
      logic [15:0] wdata;
      logic        exp_err;
      logic [15:0] exp_rdata;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_start = 1'b0;
   logic        cmd_read = 1'b0;
   logic [4:0]  cmd_phy = '0;
   logic [4:0]  cmd_reg = '0;
   logic [15:0] cmd_wdata = '0;
   logic [15:0] rd_data;
   logic        busy, done, error, mdc, mdio_o, mdio_oe, mdio_i;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   item_t exp_q[$];

   logic        phy_respond = 1'b1;
   logic [15:0] phy_data = '0;
   int          nb = 0;

   logic cap_o  [0:127];
   logic cap_oe [0:127];
   int   rises = 0;
   logic prev_mdc = 1'b0, prev_o = 1'b0, prev_oe = 1'b0;
   int   hi_run = 0, lo_run = 0, bad_len = 0, bad_hold = 0;
   bit   done_seen = 0;

   always #10 clk = ~clk;

   mdio_master #(.HALF_DIV(HALF), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .cmd_start_i(cmd_start), .cmd_read_i(cmd_read),
      .cmd_phy_i(cmd_phy), .cmd_reg_i(cmd_reg), .cmd_wdata_i(cmd_wdata),
      .rd_data_o(rd_data), .busy_o(busy), .done_o(done), .error_o(error),
      .mdc_o(mdc), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe), .mdio_i(mdio_i)
   );

   // PHY model: pull-up when silent, TA low in cycle 46, data in cycles 47..62
   assign mdio_i = !phy_respond ? 1'b1 :
                   (nb == 46) ? 1'b0 :
                   (nb >= 47 && nb <= 62) ? phy_data[62 - nb] : 1'b1;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   function automatic logic [1:0] exp_bit(input item_t it, input int i);
      logic [13:0] hdr;
      hdr = {2'b01, (it.rd ? 2'b10 : 2'b01), it.phy, it.rg};
      if (i < 32) return 2'b11;
      if (i < 46) return {1'b1, hdr[13 - (i - 32)]};
      if (it.rd) return 2'b00;
      if (i == 46) return 2'b11;
      if (i == 47) return 2'b10;
      if (i < 64) return {1'b1, it.wdata[15 - (i - 48)]};
      return 2'b00;
   endfunction

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (done_seen) begin
            check(!done, "R8", "done longer than one cycle", done, 0);
            done_seen = 0;
         end
         if (mdc && prev_mdc && (mdio_o !== prev_o || mdio_oe !== prev_oe)) bad_hold++;
         if (mdc && !prev_mdc) begin
            if (lo_run != HALF) bad_len++;
            if (rises < 128) begin
               cap_o[rises]  = mdio_o;
               cap_oe[rises] = mdio_oe;
            end
            rises++;
            hi_run = 1;
         end else if (!mdc && prev_mdc) begin
            if (hi_run != HALF) bad_len++;
            lo_run = busy ? 1 : 0;
            if (busy) nb++;
         end else if (mdc) begin
            hi_run++;
         end else begin
            lo_run = busy ? lo_run + 1 : 0;
         end
         if (!busy) nb = 0;
         if (!busy) check(!mdc, "R7", "mdc not low while idle", mdc, 0);

         if (done) begin
            item_t it;
            int n_exp, e1, e2, e45;
            check(exp_q.size() > 0, "R9", "unexpected completion", exp_q.size(), 1);
            if (exp_q.size() > 0) begin
               it = exp_q.pop_front();
               n_exp = (it.rd && it.exp_err) ? 79 : 65;
               check(rises == n_exp, it.exp_err ? "R6" : (it.rd ? "R5" : "R4"),
                     "mdc cycle count", rises, n_exp);
               e1 = 0; e2 = 0; e45 = 0;
               for (int i = 0; i < n_exp && i < 128; i++) begin
                  logic [1:0] eb;
                  eb = exp_bit(it, i);
                  if (cap_oe[i] !== eb[1] || (eb[1] && cap_o[i] !== eb[0])) begin
                     if (i < 32) e1++;
                     else if (i < 46) e2++;
                     else e45++;
                  end
               end
               check(e1 == 0, "R1", "preamble bit errors", e1, 0);
               check(e2 == 0, "R2", "header bit errors", e2, 0);
               check(e45 == 0, it.rd ? "R5" : "R4", "tail bit errors", e45, 0);
               check(error == it.exp_err, "R6", "error flag", error, it.exp_err);
               if (it.rd)
                  check(rd_data == it.exp_rdata, it.exp_err ? "R6" : "R5",
                        "read data", rd_data, it.exp_rdata);
               check(!busy, "R8", "busy still high with done", busy, 0);
               check(bad_len == 0, "R7", "mdc phase length errors", bad_len, 0);
               check(bad_hold == 0, "R3", "mdio changed while mdc high", bad_hold, 0);
            end
            rises = 0; bad_len = 0; bad_hold = 0;
            done_seen = 1;
         end
      end
      prev_mdc = mdc; prev_o = mdio_o; prev_oe = mdio_oe;
   end

   logic [15:0] last_rdata = '0;

   task automatic run_cmd(input logic rd, input logic [4:0] phy, input logic [4:0] rg,
                          input logic [15:0] wd, input logic respond,
                          input logic [15:0] pdata, input bit spurious);
      item_t it;
      it.rd = rd; it.phy = phy; it.rg = rg; it.wdata = wd;
      it.exp_err = rd && !respond;
      if (rd && respond) last_rdata = pdata;
      it.exp_rdata = last_rdata;
      exp_q.push_back(it);
      phy_respond = respond;
      phy_data = pdata;
      @(negedge clk);
      cmd_read = rd; cmd_phy = phy; cmd_reg = rg; cmd_wdata = wd; cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
      cmd_read = ~rd; cmd_phy = ~phy; cmd_reg = ~rg; cmd_wdata = ~wd;
      check(busy, "R8", "busy after accept", busy, 1);
      check(!error, "R10", "error not cleared on accept", error, 0);
      if (spurious) begin
         repeat (100) @(negedge clk);
         cmd_start = 1'b1;
         @(negedge clk);
         cmd_start = 1'b0;
      end
      while (!done) @(negedge clk);
      repeat (12) @(negedge clk);
      check(!busy, "R9", "frame restarted after completion", busy, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(!busy && !done && !error, "R11", "status after reset",
            {busy, done, error}, 0);
      check(!mdc && !mdio_oe, "R11", "mdc/oe after reset", {mdc, mdio_oe}, 0);
      check(rd_data == 16'h0, "R11", "read data after reset", rd_data, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check(!busy && !mdc, "R7", "idle after reset release", {busy, mdc}, 0);

      run_cmd(1'b0, 5'h11, 5'h0A, 16'hA53C, 1'b1, 16'h0000, 0);
      run_cmd(1'b1, 5'h03, 5'h1F, 16'h0000, 1'b1, 16'hC3A5, 0);
      run_cmd(1'b0, 5'h00, 5'h00, 16'h0001, 1'b1, 16'h0000, 1);   // R9 spurious strobe
      run_cmd(1'b1, 5'h1C, 5'h05, 16'h0000, 1'b0, 16'hFFFF, 0);   // R6 no PHY
      run_cmd(1'b1, 5'h1F, 5'h10, 16'h0000, 1'b1, 16'h8001, 1);   // R10 then R5
      run_cmd(1'b0, 5'h1F, 5'h1F, 16'hFFFF, 1'b1, 16'h0000, 0);

      check(exp_q.size() == 0, "R9", "pending items", exp_q.size(), 0);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=complete");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule